// File: doc/BRIEF.md
# Endpoint Transaction Status Queue

This block keeps a record of finished endpoint transactions so that software can deal with them one at a time. Each finished transaction produces a status byte. The byte holds the endpoint number, whether the transfer went out or came in, and which of the two descriptor banks (odd or even) was used. Up to four of these bytes wait in a first-in, first-out queue. This lets the transfer engine complete a new transaction while software is still working on an earlier one.

Software sees only the oldest waiting entry, through a status window. A done flag is high whenever the window holds a real entry. Software retires the shown entry by writing a clear to the done flag; a read of the window does not retire it. If more entries are waiting, the next one appears in the window on the following cycle and the flag stays high without a gap. If a completion arrives while the queue is full, it is thrown away and a sticky overflow indicator is set. That indicator has its own clear strobe.

Top module: `xfer_status_queue`

## Requirements
- R1: After synchronous reset the queue is empty, `done_flag` is 0, `status_byte` reads 8'h00 and `overflow` is 0.
- R2: A status byte carries the endpoint number in bits 7:4, the direction in bit 3 (1 = transmit, 0 = receive) and the bank in bit 2 (1 = odd). Bits 1:0 always read 0.
- R3: A completion strobe that arrives while the queue is empty makes `done_flag` 1 in the next cycle, and the window shows that entry.
- R4: The queue holds up to four entries and presents them oldest first. New completions do not change the entry that is already shown.
- R5: A flag clear while two or more entries are held retires the shown entry. In the next cycle the window shows the next-oldest entry and `done_flag` stays 1.
- R6: A flag clear while one entry is held empties the queue. In the next cycle `done_flag` is 0 and the window reads 8'h00.
- R7: A flag clear while `done_flag` is 0 has no effect. The flag stays 0, and a later completion is shown correctly.
- R8: A completion while four entries are held, with no clear in the same cycle, is dropped and sets `overflow`. The held entries are not changed.
- R9: `overflow` stays set until an `ovf_clr` strobe arrives. When a new overflow and `ovf_clr` happen in the same cycle, the new overflow wins and `overflow` stays 1.
- R10: A completion and a flag clear in the same cycle are both carried out, and the entry count stays the same. This also holds when the queue is full, and then `overflow` is not set. On an empty queue the clear is ignored and the completion is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_stb | input | 1 | One-cycle strobe: a transaction has completed |
| done_ep | input | 4 | Endpoint number of the completed transaction |
| done_tx | input | 1 | 1 = transmit, 0 = receive |
| done_odd | input | 1 | 1 = odd descriptor bank used |
| flag_clr | input | 1 | Write strobe that clears the done flag and retires the shown entry |
| ovf_clr | input | 1 | Write strobe that clears the overflow indicator |
| status_byte | output | 8 | Status window: the oldest entry, or 0 when the queue is empty |
| done_flag | output | 1 | High while the window holds a valid entry |
| overflow | output | 1 | Sticky: a completion was lost because the queue was full |

## Verification
The block is driven with these patterns:
- A single completion followed by its clear. This separates the flag-rise path from the flag-fall path.
- A burst of four completions with distinct field values, drained one clear at a time. This shows whether the ordering is right and whether the flag stays high between entries.
- A fifth completion into a full queue. This separates dropping the new entry from overwriting an old one, because the drain that follows must show only the original four.
- Same-cycle completion and clear, tried on an empty, a single-entry and a full queue. This is where a wrong count or a false overflow would show up.
- Clears on an idle queue, and overflow clears that coincide with a new overflow. These show that the idle clear does nothing and that the set has priority over the clear.

// File: rtl/xsq_pkg.sv
package xsq_pkg;

    localparam int EP_W   = 4;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [EP_W-1:0] ep;
        logic            is_tx;
        logic            odd;
    } xsq_entry_t;

    localparam int ENTRY_W = $bits(xsq_entry_t);

    function automatic logic [BYTE_W-1:0] xsq_to_byte(input xsq_entry_t e);
        return {e.ep, e.is_tx, e.odd, 2'b00};
    endfunction

endpackage

// File: rtl/xsq_fifo.sv
module xsq_fifo
    import xsq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  xsq_entry_t       din,
    output xsq_entry_t       dout,
    output logic             empty,
    output logic             drop,
    output logic [CNT_W-1:0] count
);

    xsq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, push_go, pop_go;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_go  = pop_req && !empty;
    assign push_go = push_req && (!full || pop_go);
    assign drop    = push_req && !push_go;
    assign dout    = mem[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push_go && wr_ptr == PTR_W'(i))
                mem[i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_go) wr_ptr <= bump(wr_ptr);
            if (pop_go)  rd_ptr <= bump(rd_ptr);
            case ({push_go, pop_go})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/xsq_sticky.sv
module xsq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/xfer_status_queue.sv
module xfer_status_queue
    import xsq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_stb,
    input  logic [EP_W-1:0]   done_ep,
    input  logic              done_tx,
    input  logic              done_odd,
    input  logic              flag_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] status_byte,
    output logic              done_flag,
    output logic              overflow
);

    xsq_entry_t       new_entry, head;
    logic             q_empty, q_drop;
    logic [CNT_W-1:0] occ;

    assign new_entry = '{ep: done_ep, is_tx: done_tx, odd: done_odd};

    xsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_req (done_stb),
        .pop_req  (flag_clr),
        .din      (new_entry),
        .dout     (head),
        .empty    (q_empty),
        .drop     (q_drop),
        .count    (occ)
    );

    xsq_sticky u_ovf (
        .clk (clk),
        .rst (rst),
        .set (q_drop),
        .clr (ovf_clr),
        .q   (overflow)
    );

    assign done_flag   = !q_empty;
    assign status_byte = q_empty ? '0 : xsq_to_byte(head);

endmodule

// File: rtl/xsq_checker.sv
module xsq_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             done_stb,
    input logic             flag_clr,
    input logic             ovf_clr,
    input logic [7:0]       status_byte,
    input logic             done_flag,
    input logic             overflow,
    input logic [CNT_W-1:0] occ
);

    assert_window_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !done_flag |-> status_byte == 8'h00);

    assert_low_bits_R2: assert property (@(posedge clk) disable iff (rst)
        status_byte[1:0] == 2'b00);

    assert_push_flags_R3: assert property (@(posedge clk) disable iff (rst)
        done_stb |=> done_flag);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (!done_flag && flag_clr && !done_stb) |=> !done_flag);

    assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH) && done_stb && !flag_clr) |=> overflow);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    assert_swap_count_R10: assert property (@(posedge clk) disable iff (rst)
        (done_flag && flag_clr && done_stb) |=> occ == $past(occ));

endmodule

bind xfer_status_queue xsq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done_stb    (done_stb),
    .flag_clr    (flag_clr),
    .ovf_clr     (ovf_clr),
    .status_byte (status_byte),
    .done_flag   (done_flag),
    .overflow    (overflow),
    .occ         (occ)
);

// File: tb/sim_xfer_status_queue.sv
`timescale 1ns/1ps
module sim_xfer_status_queue;

    logic       clk = 1'b0;
    logic       rst;
    logic       done_stb, done_tx, done_odd, flag_clr, ovf_clr;
    logic [3:0] done_ep;
    logic [7:0] status_byte;
    logic       done_flag, overflow;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xfer_status_queue u0 (
        .clk(clk), .rst(rst), .done_stb(done_stb), .done_ep(done_ep),
        .done_tx(done_tx), .done_odd(done_odd), .flag_clr(flag_clr),
        .ovf_clr(ovf_clr), .status_byte(status_byte),
        .done_flag(done_flag), .overflow(overflow)
    );

    function automatic logic [7:0] exp_byte(input logic [3:0] ep, input logic tx, input logic odd);
        return {ep, tx, odd, 2'b00};
    endfunction

    task automatic check(input string req, input logic [7:0] sb, input logic fl, input logic ov);
        total++;
        if (status_byte !== sb || done_flag !== fl || overflow !== ov) begin
            bad++;
            $display("FAIL %s: got byte=%02h flag=%b ovf=%b, expected byte=%02h flag=%b ovf=%b",
                     req, status_byte, done_flag, overflow, sb, fl, ov);
        end
    endtask

    // one clock: drive at negedge, release 1 ns after the rising edge
    task automatic cyc(input logic stb, input logic [3:0] ep, input logic tx,
                       input logic odd, input logic clr, input logic oclr);
        @(negedge clk);
        done_stb = stb; done_ep = ep; done_tx = tx; done_odd = odd;
        flag_clr = clr; ovf_clr = oclr;
        @(posedge clk);
        #1;
        done_stb = 1'b0; flag_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic push(input logic [3:0] ep, input logic tx, input logic odd);
        cyc(1'b1, ep, tx, odd, 1'b0, 1'b0);
    endtask

    task automatic clear();
        cyc(1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        done_stb = 0; done_ep = 0; done_tx = 0; done_odd = 0; flag_clr = 0; ovf_clr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_single();
        push(4'h5, 1'b1, 1'b0);
        check("R3 single push", 8'h58, 1'b1, 1'b0);
        clear();
        check("R6 last clear", 8'h00, 1'b0, 1'b0);
        push(4'hA, 1'b0, 1'b1);
        check("R2 layout rx odd", exp_byte(4'hA, 1'b0, 1'b1), 1'b1, 1'b0);
        clear();
        check("R6 last clear 2", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_order();
        push(4'h1, 1'b1, 1'b1);
        push(4'h2, 1'b0, 1'b0);
        push(4'h3, 1'b1, 1'b0);
        push(4'hF, 1'b0, 1'b1);
        check("R4 head kept after fills", exp_byte(4'h1, 1'b1, 1'b1), 1'b1, 1'b0);
        clear();
        check("R5 next entry 2", exp_byte(4'h2, 1'b0, 1'b0), 1'b1, 1'b0);
        clear();
        check("R5 next entry 3", exp_byte(4'h3, 1'b1, 1'b0), 1'b1, 1'b0);
        clear();
        check("R5 next entry 4", exp_byte(4'hF, 1'b0, 1'b1), 1'b1, 1'b0);
        clear();
        check("R6 drained", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) push(4'(i + 4), 1'b1, 1'b0);
        check("R8 full no ovf yet", exp_byte(4'h4, 1'b1, 1'b0), 1'b1, 1'b0);
        push(4'hE, 1'b0, 1'b1);
        check("R8 drop sets ovf", exp_byte(4'h4, 1'b1, 1'b0), 1'b1, 1'b1);
        for (int i = 1; i < 4; i++) begin
            clear();
            check("R8 kept entries", exp_byte(4'(i + 4), 1'b1, 1'b0), 1'b1, 1'b1);
        end
        clear();
        check("R8 dropped entry absent / R9 sticky", 8'h00, 1'b0, 1'b1);
        cyc(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 ovf clear", 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) push(4'h7, 1'b0, 1'b0);
        cyc(1'b1, 4'h9, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R9 set beats clear", exp_byte(4'h7, 1'b0, 1'b0), 1'b1, 1'b1);
        cyc(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 ovf clear again", exp_byte(4'h7, 1'b0, 1'b0), 1'b1, 1'b0);
        repeat (4) clear();
        check("R6 drained after ovf", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_idle_clear();
        clear();
        clear();
        check("R7 idle clear", 8'h00, 1'b0, 1'b0);
        push(4'h9, 1'b1, 1'b1);
        check("R7 push after idle clears", exp_byte(4'h9, 1'b1, 1'b1), 1'b1, 1'b0);
        clear();
        check("R6 drain", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_simul();
        cyc(1'b1, 4'hC, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 empty push+clear stores", exp_byte(4'hC, 1'b0, 1'b1), 1'b1, 1'b0);
        cyc(1'b1, 4'hD, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 one entry swap", exp_byte(4'hD, 1'b1, 1'b0), 1'b1, 1'b0);
        clear();
        check("R10 count kept at one", 8'h00, 1'b0, 1'b0);
        push(4'h1, 1'b0, 1'b0);
        push(4'h2, 1'b0, 1'b1);
        push(4'h3, 1'b1, 1'b0);
        push(4'h4, 1'b1, 1'b1);
        cyc(1'b1, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 full swap no ovf", exp_byte(4'h2, 1'b0, 1'b1), 1'b1, 1'b0);
        clear();
        check("R10 full swap order 3", exp_byte(4'h3, 1'b1, 1'b0), 1'b1, 1'b0);
        clear();
        check("R10 full swap order 4", exp_byte(4'h4, 1'b1, 1'b1), 1'b1, 1'b0);
        clear();
        check("R10 full swap new tail", exp_byte(4'h8, 1'b0, 1'b0), 1'b1, 1'b0);
        clear();
        check("R10 drained", 8'h00, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_order();
        t_overflow();
        t_idle_clear();
        t_simul();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule